// File: doc/BRIEF.md
# Programmable Tick-Based Clock Generator

This block derives a periodic square wave from a system clock, where one enabled clock edge counts as one tick. Parent logic sets three 16-bit tick counts: how long the output idles after reset, how long each high phase lasts and how long each low phase lasts. After the idle span the output enters a high phase and then alternates low and high for as long as the block runs. A polarity input flips the output level.

Each phase length is read when that phase begins. A new setting therefore applies from the next phase boundary and never shortens or extends the phase already running. A count of zero for a high or low phase is treated as one tick. Deasserting the enable input freezes the generator in place.

Top module: `tick_wavegen`

## Requirements
- R1: While `rst` is high at a clock edge, the generator returns to its idle phase with its tick counter cleared. The un-inverted level is low, so `wave_o` equals `invert`.
- R2: The idle count is captured on the last clock edge with `rst` high and is not reread later. If that count is D, the first D enabled ticks after reset leave the level low, and the enabled tick numbered D+1 drives it high.
- R3: When the idle count is 0, the level goes high on the first enabled tick after reset is released.
- R4: A high phase with a count H of at least 1 keeps the level high for exactly H enabled ticks.
- R5: A low phase with a count L of at least 1 keeps the level low for exactly L enabled ticks.
- R6: Once the idle span is over, phases alternate high, low, high, low, and the generator never returns to idle without a reset.
- R7: A high or low count of 0 gives a phase of exactly one enabled tick.
- R8: A phase length is sampled on the tick that enters the phase. Changes to the count inputs during a phase do not alter that phase.
- R9: A clock edge with `en` low changes neither the level nor the tick counter.
- R10: `wave_o` is the internal level XOR `invert`. A change on `invert` shows on the output in the same cycle, without waiting for a clock edge.
- R11: Phases up to 65535 ticks long run to completion. The tick counter never exceeds the length of the current phase and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each edge with `en` high is one tick |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Tick enable; low freezes the generator |
| dly_ticks | input | 16 | Idle span after reset, in ticks |
| high_ticks | input | 16 | High phase length in ticks (0 is treated as 1) |
| low_ticks | input | 16 | Low phase length in ticks (0 is treated as 1) |
| invert | input | 1 | Output polarity; 1 inverts the level |
| wave_o | output | 1 | Generated waveform |

## Verification
Assertions check on every cycle that the tick counter stays within the current phase length and that a frozen edge leaves the state unchanged. They also check that a phase cannot end before its counter reaches its length, that idle is never re-entered without reset, and that reset restores idle with a cleared counter. The exact length of each phase, the idle span and its capture at reset, and zero-count stretching can only be shown by the bench. The same holds for mid-phase configuration changes, the interaction of enable gaps with phase lengths, and the live polarity flip. The bench covers these by comparing the output cycle by cycle against a tick-count model.

// File: rtl/tick_wavegen_pkg.sv
`timescale 1ns/1ps
package tick_wavegen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } wave_phase_e;

endpackage

// File: rtl/twg_len_sel.sv
`timescale 1ns/1ps
// Picks the length of the phase about to start and converts it to the
// last counter value of that phase, stretching a zero count to one tick.
module twg_len_sel #(
    parameter int W = 16
) (
    input  logic         want_high,
    input  logic [W-1:0] high_len,
    input  logic [W-1:0] low_len,
    output logic [W-1:0] last_idx
);

    logic [W-1:0] raw_len;

    always_comb begin
        raw_len  = want_high ? high_len : low_len;
        last_idx = (raw_len == '0) ? '0 : raw_len - W'(1);
    end

endmodule

// File: rtl/twg_phase_seq.sv
`timescale 1ns/1ps
// Phase sequencer: idle span, then high/low alternation.
// cnt counts ticks already spent in the phase, tgt holds its last index.
module twg_phase_seq
    import tick_wavegen_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] start_dly,
    input  logic [W-1:0] next_last,
    output wave_phase_e  phase_o,
    output logic         want_high_o
);

    typedef struct packed {
        wave_phase_e  ph;
        logic [W-1:0] cnt;
        logic [W-1:0] tgt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
            st_d.tgt = start_dly;
        end else if (en) begin
            if (st_q.cnt == st_q.tgt) begin
                st_d.ph  = (st_q.ph == PH_HIGH) ? PH_LOW : PH_HIGH;
                st_d.cnt = '0;
                st_d.tgt = next_last;
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_o     = st_q.ph;
    assign want_high_o = (st_q.ph != PH_HIGH);

    // R11: counter stays inside the current phase, so it cannot wrap
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.tgt);

    // R9: a frozen edge leaves phase and counter untouched
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(st_q.ph) && $stable(st_q.cnt)));

    // R8: a phase is never cut short before its counter reaches the end
    a_r8_no_cut: assert property (@(posedge clk) disable iff (rst)
        (en && (st_q.cnt != st_q.tgt)) |=> $stable(st_q.ph));

    // R6: once running, idle is not re-entered without reset
    a_r6_no_idle: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph != PH_IDLE) |=> (st_q.ph != PH_IDLE));

    // R1: reset restores idle with a cleared counter
    a_r1_reset: assert property (@(posedge clk)
        rst |=> ((st_q.ph == PH_IDLE) && (st_q.cnt == '0)));

endmodule

// File: rtl/tick_wavegen.sv
`timescale 1ns/1ps
module tick_wavegen
    import tick_wavegen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] dly_ticks,
    input  logic [CNT_W-1:0] high_ticks,
    input  logic [CNT_W-1:0] low_ticks,
    input  logic             invert,
    output logic             wave_o
);

    wave_phase_e      phase;
    logic             want_high;
    logic [CNT_W-1:0] next_last;

    twg_len_sel #(.W(CNT_W)) u_len (
        .want_high (want_high),
        .high_len  (high_ticks),
        .low_len   (low_ticks),
        .last_idx  (next_last)
    );

    twg_phase_seq #(.W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .start_dly   (dly_ticks),
        .next_last   (next_last),
        .phase_o     (phase),
        .want_high_o (want_high)
    );

    // R10: polarity applied after the register, so it acts at once
    assign wave_o = (phase == PH_HIGH) ^ invert;

endmodule

// File: tb/sim_tick_wavegen.sv
`timescale 1ns/1ps
module sim_tick_wavegen;

    typedef struct {
        logic  lvl;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        inv = 1'b0;
    logic [15:0] dly = '0;
    logic [15:0] hi  = '0;
    logic [15:0] lo  = '0;
    logic        wave;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    tick_wavegen u0 (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .dly_ticks  (dly),
        .high_ticks (hi),
        .low_ticks  (lo),
        .invert     (inv),
        .wave_o     (wave)
    );

    // Level after k enabled ticks, from the requirement text.
    function automatic logic model(int k, int d, int h, int l);
        int hc, lc, t;
        hc = (h == 0) ? 1 : h;
        lc = (l == 0) ? 1 : l;
        t  = k - (d + 1);
        if (t < 0) return 1'b0;
        return ((t % (hc + lc)) < hc);
    endfunction

    task automatic check(logic act, logic expv, string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, expv, $time);
        end
    endtask

    // Monitor: one expected item consumed per clock edge, sampled after it.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(wave, e.lvl, e.tag);
        end
    end

    task automatic do_reset(int d, int h, int l, logic i);
        @(negedge clk);
        rst = 1'b1; en = 1'b1;
        dly = 16'(d); hi = 16'(h); lo = 16'(l); inv = i;
        @(negedge clk);
        check(wave, i, "R1");
    endtask

    task automatic step(logic e, logic expv, string tag);
        @(negedge clk);
        rst = 1'b0;
        en  = e;
        q.push_back('{expv, tag});
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic run_plain(int d, int h, int l, logic i, int n, string tag);
        do_reset(d, h, l, i);
        for (int k = 1; k <= n; k++) step(1'b1, model(k, d, h, l) ^ i, tag);
        drain();
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R2 R4 R5 R6: idle of 3, later writes to the idle count ignored
        do_reset(3, 2, 4, 1'b0);
        for (int k = 1; k <= 30; k++) begin
            step(1'b1, model(k, 3, 2, 4), "R2_R4_R5_R6");
            if (k == 1) dly = 16'd0;
        end
        drain();

        // R3: zero idle span, one-tick phases
        run_plain(0, 1, 1, 1'b0, 12, "R3");

        // R7: zero high and low counts stretch to one tick
        run_plain(2, 0, 0, 1'b0, 12, "R7");

        // R10: inverted polarity throughout
        run_plain(1, 3, 2, 1'b1, 20, "R10");

        // R9: every third edge frozen
        begin
            int k = 0;
            do_reset(2, 3, 2, 1'b0);
            for (int c = 0; c < 40; c++) begin
                logic e = (c % 3) != 2;
                if (e) k++;
                step(e, model(k, 2, 3, 2), "R9");
            end
            drain();
        end

        // R8: counts change mid high phase; high of 10 completes, then 3 low, 2 high
        do_reset(0, 10, 10, 1'b0);
        for (int c = 1; c <= 18; c++) begin
            logic x;
            if (c == 4) begin hi = 16'd2; lo = 16'd3; end
            x = (c <= 10) ? 1'b1 : (c <= 13) ? 1'b0 : (c <= 15) ? 1'b1 : 1'b0;
            step(1'b1, x, "R8");
        end
        drain();

        // R11: long phase runs its full length
        run_plain(0, 1000, 5, 1'b0, 1010, "R11");

        // R10: live polarity flip with no clock edge in between
        do_reset(5, 1, 1, 1'b0);
        inv = 1'b1; #0.5;
        check(wave, 1'b1, "R10");
        inv = 1'b0; #0.5;
        check(wave, 1'b0, "R10");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule